// File: doc/BRIEF.md
# One-Time-Programmable Word Memory

A synthesizable cycle-level model of a 16-bit-wide memory whose bits can only be cleared once written. It samples two active-low enables, a program-voltage flag and a signature-select flag on every clock edge. From these it derives one of seven modes: read, output disable, standby, program, verify, program inhibit and identification. The number of words is a parameter, kept small for simulation. The data output is modelled as a tri-state bus, with a separate drive flag next to the data lines.

Reset stands for a full erase and sets every word to all ones. A program pulse is the chip enable held low while the program-voltage flag is asserted and output enable is high. When chip enable rises, the pulse ANDs the captured input word into the addressed location. Bits that are already zero therefore stay zero. In identification mode the block returns one of two fixed codes instead of stored data, and address bit 0 picks which one.

Top module: `otp_word_mem`

## Requirements
- R1: After reset, `q_en` is 0 and every location reads 0xFFFF.
- R2: If a clock edge samples `ce_n`=0, `oe_n`=0 and `sig_hv`=0, then after that edge `q_en`=1 and `q` holds the word at `addr`. This applies with `vpp_hi`=0.
- R3: If a clock edge samples `ce_n`=1 with `vpp_hi`=0, then after that edge `q_en`=0 and `q`=0, whatever `oe_n` and `sig_hv` are. `q` is always 0 whenever `q_en` is 0.
- R4: If a clock edge samples `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, then after that edge `q_en`=0. `q_en` drops in the first cycle after either enable deasserts.
- R5: A program pulse is one or more edges that sample `vpp_hi`=1, `oe_n`=1 and `ce_n`=0. The pulse is committed at the first following edge that samples `ce_n`=1 and `vpp_hi`=1. At that edge the location at the captured address becomes old AND the captured `d`, where the captured values are those of the last pulse edge.
- R6: Programming never turns a stored 0 into a 1. A pulse with `d`=0xFFFF leaves the word unchanged.
- R7: If a clock edge samples `vpp_hi`=1, `ce_n`=1 and `oe_n`=0 (verify), then after that edge `q_en`=1 and `q` holds the word at `addr`.
- R8: If a clock edge samples `vpp_hi`=1, `ce_n`=1 and `oe_n`=1 with no pulse pending (inhibit), then `q_en`=0 and no location changes.
- R9: If a clock edge samples `sig_hv`=1, `vpp_hi`=0, `ce_n`=0 and `oe_n`=0, then after that edge `q_en`=1. `q` is 0x0020 when `addr[0]`=0 and 0x0044 when `addr[0]`=1, and `q[15:8]` is 0.
- R10: With `vpp_hi`=1 and both enables low, the block reads like R2 and does not program.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the whole array to ones |
| ce_n | input | 1 | Active-low chip enable; low for a program pulse |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Program-voltage flag |
| sig_hv | input | 1 | Signature-select flag (identification mode) |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| d | input | 16 | Word to program |
| q | output | 16 | Data bus value; 0 while floating |
| q_en | output | 1 | Data bus drive flag; 0 means high impedance |

## Verification
A single word is programmed several times in a row. The patterns are 0x1234, then 0xF0F0 over it, then 0xFFFF. The result, 0x1030, can only come from an AND of the inputs; replacing the word or ORing into it gives a different value. A pattern with both enables low while the program-voltage flag is high separates read from program. Each enable combination is tried with and without the two flags, so that standby, disable, inhibit and identification stay distinct. Each of the two addresses used for identification has a different bit 0. The lowest and highest addresses are programmed to show that a write reaches only its own location. A reset in the middle of the run shows the erase.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_OFF,
    MD_READ,
    MD_BURN,
    MD_CHECK,
    MD_HOLD,
    MD_IDENT
  } otp_mode_e;

  localparam logic [7:0] ID_VENDOR = 8'h20;
  localparam logic [7:0] ID_PART   = 8'h44;

  // A burn can only clear bits.
  function automatic logic [15:0] burn_word(input logic [15:0] old_w,
                                            input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic [7:0] ident_code(input logic sel);
    return sel ? ID_PART : ID_VENDOR;
  endfunction

  function automatic logic drives_bus(input otp_mode_e m);
    return (m == MD_READ) || (m == MD_CHECK) || (m == MD_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  input  logic      sig_hv,
  output otp_mode_e mode
);

  always_comb begin
    if (vpp_hi) begin
      unique case ({ce_n, oe_n})
        2'b01:   mode = MD_BURN;
        2'b10:   mode = MD_CHECK;
        2'b11:   mode = MD_HOLD;
        default: mode = MD_READ;
      endcase
    end else if (ce_n) begin
      mode = MD_STANDBY;
    end else if (oe_n) begin
      mode = MD_OFF;
    end else if (sig_hv) begin
      mode = MD_IDENT;
    end else begin
      mode = MD_READ;
    end
  end

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_pulse,
  input  logic          ce_n,
  input  logic          vpp_hi,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);

  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else if (ce_n) begin
      pend <= 1'b0;
    end else begin
      pend <= in_pulse;
      if (in_pulse) begin
        commit_addr <= addr;
        commit_data <= d;
      end
    end
  end

  assign commit = pend && ce_n && vpp_hi;

  // R5: a commit only follows a cycle with the chip enable held low
  p_commit_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(ce_n));

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] old_word;

  assign old_word = cells[waddr];
  assign rdata    = cells[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr) begin
      cells[waddr] <= burn_word(old_word, wdata);
    end
  end

  logic [AW-1:0] chk_addr;
  logic [DW-1:0] chk_old;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_addr <= '0;
      chk_old  <= '1;
    end else begin
      chk_addr <= waddr;
      chk_old  <= old_word;
    end
  end

  // R6: after a write, no bit that was 0 has become 1
  p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((cells[chk_addr] & ~chk_old) == '0));

endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hi,
  input  logic          sig_hv,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          q_en
);

  otp_mode_e     mode;
  logic          burn_evt;
  logic [AW-1:0] burn_addr;
  logic [DW-1:0] burn_data;
  logic [DW-1:0] cell_word;
  logic          drive_evt;
  logic [DW-1:0] next_q;

  otp_mode_decode u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .sig_hv (sig_hv),
    .mode   (mode)
  );

  otp_burn_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_pulse    (mode == MD_BURN),
    .ce_n        (ce_n),
    .vpp_hi      (vpp_hi),
    .addr        (addr),
    .d           (d),
    .commit      (burn_evt),
    .commit_addr (burn_addr),
    .commit_data (burn_data)
  );

  otp_cell_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (burn_evt),
    .waddr (burn_addr),
    .wdata (burn_data),
    .raddr (addr),
    .rdata (cell_word)
  );

  assign drive_evt = drives_bus(mode);

  always_comb begin
    if (!drive_evt)          next_q = '0;
    else if (mode == MD_IDENT) next_q = {{(DW-8){1'b0}}, ident_code(addr[0])};
    else                     next_q = cell_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_en <= 1'b0;
      q    <= '0;
    end else begin
      q_en <= drive_evt;
      q    <= next_q;
    end
  end

  // R3: standby floats the bus on the next cycle
  p_standby_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |=> (!q_en && q == '0));

  // R4: output disable floats the bus on the next cycle
  p_disable_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |=> !q_en);

  // R2: both enables low gives a driven bus on the next cycle
  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi) |=> q_en);

  // R9: identification codes keep the upper byte clear
  p_ident_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && sig_hv) |=> (q_en && q[DW-1:8] == '0));

  // R8: inhibit never drives the bus
  p_inhibit_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && oe_n && vpp_hi) |=> !q_en);

endmodule

// File: tb/test_otp_word_mem.sv
`timescale 1ns/1ps
module test_otp_word_mem;

  localparam int DEPTH = 256;
  localparam int AW    = 8;

  typedef struct packed {
    logic        ce_n;
    logic        oe_n;
    logic        vpp;
    logic        sig;
    logic [7:0]  a;
    logic [15:0] d;
    logic        en;
    logic [15:0] q;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,8'h05,16'h0000,1'b1,16'hFFFF,4'd1},  // R1 erased word reads ones
    '{1'b0,1'b1,1'b1,1'b0,8'h05,16'h1234,1'b0,16'h0000,4'd5},  // R5 pulse low
    '{1'b1,1'b1,1'b1,1'b0,8'h05,16'h0000,1'b0,16'h0000,4'd8},  // R8 float while committing
    '{1'b0,1'b0,1'b0,1'b0,8'h05,16'h0000,1'b1,16'h1234,4'd5},  // R5 programmed value
    '{1'b0,1'b1,1'b1,1'b0,8'h05,16'hF0F0,1'b0,16'h0000,4'd5},  // R5 second pulse
    '{1'b1,1'b1,1'b1,1'b0,8'h05,16'h0000,1'b0,16'h0000,4'd5},  // R5 commit
    '{1'b1,1'b0,1'b1,1'b0,8'h05,16'h0000,1'b1,16'h1030,4'd7},  // R7 verify shows AND
    '{1'b0,1'b1,1'b1,1'b0,8'h05,16'hFFFF,1'b0,16'h0000,4'd6},  // R6 pulse with ones
    '{1'b1,1'b1,1'b1,1'b0,8'h05,16'h0000,1'b0,16'h0000,4'd6},  // R6 commit
    '{1'b0,1'b0,1'b0,1'b0,8'h05,16'h0000,1'b1,16'h1030,4'd6},  // R6 zeros kept
    '{1'b1,1'b0,1'b0,1'b0,8'h05,16'h0000,1'b0,16'h0000,4'd3},  // R3 standby oe low
    '{1'b1,1'b1,1'b0,1'b1,8'h05,16'h0000,1'b0,16'h0000,4'd3},  // R3 standby with sig
    '{1'b0,1'b1,1'b0,1'b0,8'h05,16'h0000,1'b0,16'h0000,4'd4},  // R4 output disable
    '{1'b0,1'b0,1'b0,1'b1,8'h02,16'h0000,1'b1,16'h0020,4'd9},  // R9 vendor code
    '{1'b0,1'b0,1'b0,1'b1,8'h03,16'h0000,1'b1,16'h0044,4'd9},  // R9 part code
    '{1'b0,1'b0,1'b1,1'b0,8'h05,16'h0000,1'b1,16'h1030,4'd10}, // R10 read with vpp
    '{1'b1,1'b1,1'b0,1'b0,8'h05,16'h0000,1'b0,16'h0000,4'd3},  // R3 drop after read
    '{1'b0,1'b0,1'b0,1'b0,8'h05,16'h0000,1'b1,16'h1030,4'd10}, // R10 no write happened
    '{1'b0,1'b0,1'b0,1'b0,8'h06,16'h0000,1'b1,16'hFFFF,4'd2},  // R2 neighbour untouched
    '{1'b1,1'b1,1'b1,1'b0,8'h06,16'h0000,1'b0,16'h0000,4'd8},  // R8 inhibit
    '{1'b0,1'b0,1'b0,1'b0,8'h06,16'h0000,1'b1,16'hFFFF,4'd8}   // R8 nothing written
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, sig_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   d = '0;
  logic [15:0]   q;
  logic          q_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  otp_word_mem #(.DEPTH(DEPTH)) i_otp_word_mem (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .sig_hv(sig_hv), .addr(addr), .d(d), .q(q), .q_en(q_en)
  );

  task automatic check(input int req, input logic en_exp, input logic [15:0] q_exp);
    n_chk++;
    if (q_en !== en_exp) begin
      n_bad++;
      $display("FAIL R%0d q_en actual %b expected %b", req, q_en, en_exp);
    end
    n_chk++;
    if (q !== q_exp) begin
      n_bad++;
      $display("FAIL R%0d q actual %h expected %h", req, q, q_exp);
    end
  endtask

  task automatic step(input logic c, input logic o, input logic v, input logic s,
                      input logic [7:0] a, input logic [15:0] w);
    ce_n = c; oe_n = o; vpp_hi = v; sig_hv = s; addr = a; d = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 16'h0000);  // R1 idle after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ce_n, VEC[i].oe_n, VEC[i].vpp, VEC[i].sig, VEC[i].a, VEC[i].d);
      check(int'(VEC[i].req), VEC[i].en, VEC[i].q);
    end

    // R5 edges of the address range, multi-cycle pulse keeps last data
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 16'h0F0F);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 16'h0001);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 16'h0000);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 16'h0000);
    check(5, 1'b1, 16'h0001);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000);
    check(5, 1'b1, 16'hFFFF);
    // R4 bus drops the cycle after oe_n rises
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0000);
    check(4, 1'b0, 16'h0000);

    // R1 reset erases programmed words
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 16'h0000);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 16'h0000);
    check(1, 1'b1, 16'hFFFF);
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h05, 16'h0000);
    check(1, 1'b1, 16'hFFFF);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule